// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises port-to-port interrupts for a two-port shared memory. The two highest words of the address space act as mailboxes. The top word (all ones) belongs to the right port, and the word just below it belongs to the left port. When one port writes the other port's mailbox, the block pulls the owner's active-low interrupt low. The owner clears that interrupt by reading its own mailbox. The message itself is stored in the ordinary memory array, which sits outside this block.

The block watches each port's access signals as plain control pins. These are chip enable, write strobe, output enable, address and a busy flag, all active low. A port whose busy flag is active cannot set the other side's interrupt and cannot clear its own. Each interrupt is held in a register that takes its next value on the clock edge after the access that caused it.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both `irq_l_n` and `irq_r_n` are high (inactive).
- R2: A left write (`l_en_n`=0, `l_we_n`=0, `l_busy_n`=1) to address all-ones drives `irq_r_n` low on the next clock edge.
- R3: A right write (`r_en_n`=0, `r_we_n`=0, `r_busy_n`=1) to address all-ones minus one drives `irq_l_n` low on the next clock edge.
- R4: An owner read (enable 0, write strobe 1, output enable 0, busy 1) of its own mailbox returns its interrupt high on the next edge. For the right port the mailbox is all-ones; for the left port it is all-ones minus one.
- R5: A port that reads the other port's mailbox leaves the other port's interrupt unchanged.
- R6: A write to the peer mailbox while the writer's busy flag is 0 leaves the peer interrupt unchanged.
- R7: A read of the own mailbox while the reader's busy flag is 0 leaves that interrupt unchanged.
- R8: An access counts only when the port's enable is 0. A read additionally needs output enable 0 and write strobe 1. A strobe without enable, or a read with output enable 1, has no effect.
- R9: If a set and a clear of the same interrupt fall in the same cycle, the interrupt ends low (the set wins).
- R10: Accesses to any address other than the two mailboxes leave both interrupts unchanged, and a set interrupt stays low until it is cleared.
- R11: Every interrupt change appears exactly one clock edge after the access, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en_n | input | 1 | Left port enable, active low |
| l_we_n | input | 1 | Left write strobe, low = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy flag, active low |
| l_addr | input | ADDR_W | Left address |
| r_en_n | input | 1 | Right port enable, active low |
| r_we_n | input | 1 | Right write strobe, low = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy flag, active low |
| r_addr | input | ADDR_W | Right address |
| irq_l_n | output | 1 | Interrupt to the left port, active low |
| irq_r_n | output | 1 | Interrupt to the right port, active low |

## Verification
The two functions that can share a cycle are setting an interrupt and clearing it. This happens when one port writes a mailbox in the same cycle that the owner reads it. The bench provokes this case directly for both mailboxes. It also sweeps every combination of both ports' control bits and addresses over a 3-bit address space, so the overlap also occurs with busy flags in every state. After each edge, the bench compares both interrupt outputs with a next-state value that it computes from the requirements. In that computation a qualifying set overrides a qualifying clear.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;

  // qualified mailbox events produced by one port
  typedef struct packed {
    logic set_peer;  // write to the other port's mailbox, not busy
    logic clr_own;   // read of own mailbox, not busy
  } mbx_evt_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter bit IS_RIGHT = 1'b0
) (
  input  logic              en_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output mbx_evt_t          evt
);
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;
  localparam logic [ADDR_W-1:0] OWN_BOX  = IS_RIGHT ? BOX_R : BOX_L;
  localparam logic [ADDR_W-1:0] PEER_BOX = IS_RIGHT ? BOX_L : BOX_R;

  logic wr_cyc, rd_cyc;

  always_comb begin
    wr_cyc = !en_n && !we_n;
    rd_cyc = !en_n && we_n && !oe_n;
    evt.set_peer = wr_cyc && busy_n && (addr == PEER_BOX);
    evt.clr_own  = rd_cyc && busy_n && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_n <= 1'b1;
    else if (set_i) irq_n <= 1'b0;
    else if (clr_i) irq_n <= 1'b1;
  end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              irq_l_n,
  output logic              irq_r_n
);
  logic [NUM_PORTS-1:0]             en_n_v, we_n_v, oe_n_v, busy_n_v, irq_n_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
  mbx_evt_t [NUM_PORTS-1:0]         evt_v;

  assign en_n_v   = {r_en_n, l_en_n};
  assign we_n_v   = {r_we_n, l_we_n};
  assign oe_n_v   = {r_oe_n, l_oe_n};
  assign busy_n_v = {r_busy_n, l_busy_n};
  assign addr_v   = {r_addr, l_addr};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .IS_RIGHT(p == PORT_R)
    ) dec_i (
      .en_n  (en_n_v[p]),
      .we_n  (we_n_v[p]),
      .oe_n  (oe_n_v[p]),
      .busy_n(busy_n_v[p]),
      .addr  (addr_v[p]),
      .evt   (evt_v[p])
    );

    // interrupt p is set by the opposite port and cleared by its owner
    mbx_irq_flag flag_i (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(evt_v[NUM_PORTS-1-p].set_peer),
      .clr_i(evt_v[p].clr_own),
      .irq_n(irq_n_v[p])
    );
  end

  assign irq_l_n = irq_n_v[PORT_L];
  assign irq_r_n = irq_n_v[PORT_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic              l_busy_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en_n,
  input logic              r_we_n,
  input logic              r_oe_n,
  input logic              r_busy_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              irq_l_n,
  input logic              irq_r_n
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NXT = TOP - 1'b1;

  logic l_wr, r_wr, l_rd, r_rd;
  assign l_wr = !l_en_n && !l_we_n;
  assign r_wr = !r_en_n && !r_we_n;
  assign l_rd = !l_en_n && l_we_n && !l_oe_n;
  assign r_rd = !r_en_n && r_we_n && !r_oe_n;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq_l_n && irq_r_n));

  assert_set_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_busy_n && l_addr == TOP) |=> !irq_r_n);

  assert_set_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr && r_busy_n && r_addr == NXT) |=> !irq_l_n);

  assert_clear_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd && r_busy_n && r_addr == TOP && !(l_wr && l_busy_n && l_addr == TOP)) |=> irq_r_n);

  assert_busy_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_r_n && !l_busy_n) |=> irq_r_n);

  assert_busy_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_l_n && !l_busy_n) |=> !irq_l_n);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en_n && r_en_n) |=> ($stable(irq_l_n) && $stable(irq_r_n)));
endmodule

bind mbx_irq_ctrl mbx_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .l_en_n(l_en_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
  .r_en_n(r_en_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
  .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
);

// File: tb/mbx_irq_ctrl_tb_top.sv
module mbx_irq_ctrl_tb_top;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] TOP = 3'b111;
  localparam logic [AW-1:0] NXT = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en_n = 1, l_we_n = 1, l_oe_n = 1, l_busy_n = 1;
  logic r_en_n = 1, r_we_n = 1, r_oe_n = 1, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic irq_l_n, irq_r_n;
  logic exp_l = 1'b1, exp_r = 1'b1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbx_irq_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(l_en_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
    .r_en_n(r_en_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
    .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
  );

  task automatic check(input string req, input logic act_l, input logic act_r,
                       input logic e_l, input logic e_r);
    checks++;
    if (act_l !== e_l || act_r !== e_r) begin
      errors++;
      $display("FAIL %s: irq_l_n/irq_r_n actual %b%b expected %b%b", req, act_l, act_r, e_l, e_r);
    end
  endtask

  // port code: 0 idle, 1 write, 2 read, 3 read with oe high, 4 write without enable
  task automatic drive(input int lc, input logic [AW-1:0] la, input logic lb,
                       input int rc, input logic [AW-1:0] ra, input logic rb);
    @(negedge clk);
    l_en_n = !(lc inside {1, 2, 3}); l_we_n = (lc != 1 && lc != 4);
    l_oe_n = (lc != 2); l_addr = la; l_busy_n = lb;
    r_en_n = !(rc inside {1, 2, 3}); r_we_n = (rc != 1 && rc != 4);
    r_oe_n = (rc != 2); r_addr = ra; r_busy_n = rb;
  endtask

  task automatic step_check(input string req, input logic e_l, input logic e_r);
    @(posedge clk); #1;
    check(req, irq_l_n, irq_r_n, e_l, e_r);
  endtask

  task automatic idle();
    drive(0, '0, 1, 0, '0, 1);
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", irq_l_n, irq_r_n, 1, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1", irq_l_n, irq_r_n, 1, 1);

    // R11: left write to right box, not visible before the edge
    drive(1, TOP, 1, 0, '0, 1);
    #0.5 check("R11", irq_l_n, irq_r_n, 1, 1);
    step_check("R2", 1, 0);
    idle(); step_check("R10", 1, 0);
    // R5: left reads right mailbox -> no clear
    drive(2, TOP, 1, 0, '0, 1); step_check("R5", 1, 0);
    // R7: right reads own box while busy
    drive(0, '0, 1, 2, TOP, 0); step_check("R7", 1, 0);
    // R8: read with oe high
    drive(0, '0, 1, 3, TOP, 1); step_check("R8", 1, 0);
    // R10: other addresses
    drive(1, 3'd2, 1, 2, 3'd0, 1); step_check("R10", 1, 0);
    // R4: right clears
    drive(0, '0, 1, 2, TOP, 1); step_check("R4", 1, 1);
    // R6: busy writer can not set
    drive(1, TOP, 0, 1, NXT, 0); step_check("R6", 1, 1);
    // R8: write strobe without enable
    drive(4, TOP, 1, 4, NXT, 1); step_check("R8", 1, 1);
    // R3: right sets left
    drive(0, '0, 1, 1, NXT, 1); step_check("R3", 0, 1);
    // R5: right reads left box
    drive(0, '0, 1, 2, NXT, 1); step_check("R5", 0, 1);
    // R4: left clears own
    drive(2, NXT, 1, 0, '0, 1); step_check("R4", 1, 1);
    // R9: set and clear in the same cycle, both mailboxes
    drive(0, '0, 1, 1, NXT, 1); step_check("R3", 0, 1);
    drive(2, NXT, 1, 1, NXT, 1); step_check("R9", 0, 1);
    drive(1, TOP, 1, 2, TOP, 1); step_check("R9", 0, 0);
    drive(2, NXT, 1, 2, TOP, 1); step_check("R4", 1, 1);

    // R11 sweep over all control/address combinations of both ports
    exp_l = irq_l_n; exp_r = irq_r_n;
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      logic lw, lr, rw, rr, sl, sr, cl, cr;
      v = 14'((i * 5821) & 16383);
      @(negedge clk);
      {r_addr, r_busy_n, r_oe_n, r_we_n, r_en_n, l_addr, l_busy_n, l_oe_n, l_we_n, l_en_n} = v;
      lw = !l_en_n && !l_we_n; lr = !l_en_n && l_we_n && !l_oe_n;
      rw = !r_en_n && !r_we_n; rr = !r_en_n && r_we_n && !r_oe_n;
      sr = lw && l_busy_n && l_addr == TOP;
      sl = rw && r_busy_n && r_addr == NXT;
      cr = rr && r_busy_n && r_addr == TOP;
      cl = lr && l_busy_n && l_addr == NXT;
      exp_l = sl ? 1'b0 : (cl ? 1'b1 : exp_l);
      exp_r = sr ? 1'b0 : (cr ? 1'b1 : exp_r);
      step_check("R11", exp_l, exp_r);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule